// File: doc/BRIEF.md
# Device Enumeration Bus Controller

This block is a memory-mapped controller through which a processor finds out which devices sit in the system. It holds a table of up to 16 device records. Each record has a name length, an id, an I/O base, an I/O size, a first IRQ line and an IRQ line count, plus a flag that marks it as already reported. Software restarts a scan by writing zero to the operation register. It then reads that same register over and over. Each read moves to the next record that has not yet been reported and answers 8 ("add device") or 0 ("done"). While a record is current, the property registers show its fields. A single interrupt line tells software that unreported records exist.

Entry 0 is always the controller itself. Other records are appended through a load port with valid/ready flow control. The port accepts a record in any cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` stays high while the table has a free slot. A held-off source must keep its record stable until it is accepted. The name copy itself happens outside the block. Software first writes the upper half of a destination address, then writes the lower half to the name register. The controller answers with a one-cycle request that carries the full 64-bit address and the index of the current record. This request has no back-pressure: a consumer must take it in the cycle it appears. Software issues at most one register access per cycle; a write in the same cycle as a read is dropped.

Top module: `enum_bus_ctrl`

## Requirements
- R1: After reset `irq`, `op_err`, `reg_rd_valid` and `copy_valid` are 0 and `ld_ready` is 1. The table then holds only entry 0, and no record is current.
- R2: A read accepted at a clock edge gives `reg_rd_valid`=1 and its data one edge later. The register offsets are: operation 0x00, name copy 0x04, name length 0x08, id 0x0C, I/O base 0x10, I/O size 0x14, first IRQ 0x18, IRQ count 0x1C and name address upper half 0x20.
- R3: Writing 0 to the operation register clears every reported flag and leaves no record current. It also sets `irq` to 1.
- R4: Reads of the operation register step through unreported records in table order and answer 8 for each one. Entry 0 shows id 0xFFFFFFFF, base 0x10001000, size 0x1000, first IRQ 1, IRQ count 1 and name length 16.
- R5: A record that has been reported is skipped until the next restart. After a "done" answer, the next operation read starts again at entry 0 and finds only records still unreported.
- R6: An operation read that finds no record answers 0 and drops `irq`. No other event lowers `irq`.
- R7: When no record is current, every property register reads 0.
- R8: Writing a nonzero value to the operation register sets `op_err`, which stays set until reset. The write does not change the reported flags, the current record or `irq`.
- R9: A write to the name register while a record is current pulses `copy_valid` for exactly one cycle, one edge after the write. The pulse carries `copy_addr` = {last upper-half value, written value} and `copy_index` = the current record's index.
- R10: A write to the name register while no record is current gives no `copy_valid` pulse.
- R11: An accepted load appends a record at the next free index and sets `irq` to 1 one edge later. `ld_ready` goes to 0 once the table holds 16 records.
- R12: A record appended during a scan is found by later operation reads of that same scan.
- R13: The name and upper-half registers read as 0. Writes to the property registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rd_valid | output | 1 | Read data valid, one edge after a read |
| reg_rd_data | output | 32 | Read data |
| irq | output | 1 | Unreported devices exist |
| op_err | output | 1 | Sticky flag: an invalid operation value was written |
| ld_valid | input | 1 | Load record offered |
| ld_ready | output | 1 | Table has a free slot |
| ld_name_len | input | 32 | Record name length |
| ld_id | input | 32 | Record id |
| ld_io_base | input | 32 | Record I/O base |
| ld_io_size | input | 32 | Record I/O size |
| ld_irq_base | input | 32 | Record first IRQ line |
| ld_irq_count | input | 32 | Record IRQ count |
| copy_valid | output | 1 | Name copy request pulse |
| copy_addr | output | 64 | Name destination address |
| copy_index | output | 4 | Index of the record to copy |

## Verification
The assertions check the following on every cycle. `irq` only falls together with a valid zero read answer. An operation read can only answer 0 or 8. A restart or an accepted load always leaves `irq` high. The error flag never clears. Every copy pulse traces back to a name write with matching low address bits. What only the bench scenarios can show is the scan order itself: that reported records are skipped after a "done", that records appended in the middle of a scan are found, that an invalid operation write leaves the scan where it was, and that property values match the right record.

// File: rtl/enum_bus_pkg.sv
package enum_bus_pkg;

  typedef struct packed {
    logic [31:0] name_len;
    logic [31:0] id;
    logic [31:0] io_base;
    logic [31:0] io_size;
    logic [31:0] irq_base;
    logic [31:0] irq_cnt;
  } dev_rec_t;

  localparam logic [7:0] OFS_OP       = 8'h00;
  localparam logic [7:0] OFS_NAME_CPY = 8'h04;
  localparam logic [7:0] OFS_NAME_LEN = 8'h08;
  localparam logic [7:0] OFS_ID       = 8'h0C;
  localparam logic [7:0] OFS_IO_BASE  = 8'h10;
  localparam logic [7:0] OFS_IO_SIZE  = 8'h14;
  localparam logic [7:0] OFS_IRQ_BASE = 8'h18;
  localparam logic [7:0] OFS_IRQ_CNT  = 8'h1C;
  localparam logic [7:0] OFS_NAME_HI  = 8'h20;

  localparam logic [31:0] CMD_RESTART = 32'd0;
  localparam logic [31:0] ANS_ADD     = 32'd8;
  localparam logic [31:0] ANS_DONE    = 32'd0;

endpackage

// File: rtl/enum_dev_table.sv
module enum_dev_table
  import enum_bus_pkg::*;
#(
  parameter int          MAX_DEV       = 16,
  parameter int          IDXW          = 4,
  parameter int          CNTW          = 5,
  parameter logic [31:0] SELF_NAME_LEN = 32'd16,
  parameter logic [31:0] SELF_ID       = 32'hFFFF_FFFF,
  parameter logic [31:0] SELF_BASE     = 32'h1000_1000,
  parameter logic [31:0] SELF_SIZE     = 32'h0000_1000,
  parameter logic [31:0] SELF_IRQ      = 32'd1,
  parameter logic [31:0] SELF_IRQ_CNT  = 32'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  input  dev_rec_t        ld_rec,
  output logic            ld_ready,
  output logic            ld_fire,
  output logic [CNTW-1:0] count,
  input  logic [IDXW-1:0] rd_idx,
  output dev_rec_t        rd_rec
);

  dev_rec_t slot [MAX_DEV];

  assign ld_ready = (count < CNTW'(MAX_DEV));
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= CNTW'(1);
    else if (ld_fire) count <= count + CNTW'(1);
  end

  for (genvar g = 0; g < MAX_DEV; g++) begin : g_slot
    if (g == 0) begin : g_self
      assign slot[g] = '{name_len: SELF_NAME_LEN, id: SELF_ID,
                         io_base: SELF_BASE, io_size: SELF_SIZE,
                         irq_base: SELF_IRQ, irq_cnt: SELF_IRQ_CNT};
    end else begin : g_ext
      dev_rec_t rec_q;
      always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else if (ld_fire && (count == CNTW'(g))) rec_q <= ld_rec;
      end
      assign slot[g] = rec_q;
    end
  end

  assign rd_rec = slot[rd_idx];

endmodule

// File: rtl/enum_scan.sv
module enum_scan #(
  parameter int MAX_DEV = 16,
  parameter int IDXW    = 4,
  parameter int CNTW    = 5
) (
  input  logic [CNTW-1:0]    count,
  input  logic [MAX_DEV-1:0] reported,
  input  logic [CNTW-1:0]    start_idx,
  output logic               found,
  output logic [IDXW-1:0]    hit_idx
);

  logic [MAX_DEV-1:0] eligible;

  for (genvar g = 0; g < MAX_DEV; g++) begin : g_elig
    assign eligible[g] = (CNTW'(g) >= start_idx) && (CNTW'(g) < count) && !reported[g];
  end

  // lowest eligible index wins
  always_comb begin
    found   = 1'b0;
    hit_idx = '0;
    for (int g = MAX_DEV - 1; g >= 0; g--) begin
      if (eligible[g]) begin
        found   = 1'b1;
        hit_idx = IDXW'(g);
      end
    end
  end

endmodule

// File: rtl/enum_regif.sv
module enum_regif
  import enum_bus_pkg::*;
#(
  parameter int MAX_DEV = 16,
  parameter int IDXW    = 4,
  parameter int CNTW    = 5,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_rd_en,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               reg_rd_valid,
  output logic [31:0]        reg_rd_data,
  output logic               irq,
  output logic               op_err,
  input  logic               ld_fire,
  input  logic [CNTW-1:0]    count,
  output logic [IDXW-1:0]    cur_idx,
  input  dev_rec_t           cur_rec,
  output logic [MAX_DEV-1:0] reported,
  output logic [CNTW-1:0]    start_idx,
  input  logic               found,
  input  logic [IDXW-1:0]    hit_idx,
  output logic               copy_valid,
  output logic [63:0]        copy_addr,
  output logic [IDXW-1:0]    copy_index
);

  logic        cur_valid;
  logic [31:0] name_hi;
  logic [31:0] prop_val;
  logic        wr_ok;
  logic [7:0]  ofs;

  assign ofs       = 8'(reg_addr);
  assign wr_ok     = reg_wr_en && !reg_rd_en;
  assign start_idx = cur_valid ? (CNTW'(cur_idx) + CNTW'(1)) : '0;

  always_comb begin
    prop_val = '0;
    if (cur_valid) begin
      case (ofs)
        OFS_NAME_LEN: prop_val = cur_rec.name_len;
        OFS_ID:       prop_val = cur_rec.id;
        OFS_IO_BASE:  prop_val = cur_rec.io_base;
        OFS_IO_SIZE:  prop_val = cur_rec.io_size;
        OFS_IRQ_BASE: prop_val = cur_rec.irq_base;
        OFS_IRQ_CNT:  prop_val = cur_rec.irq_cnt;
        default:      prop_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_valid <= 1'b0;
      reg_rd_data  <= '0;
      irq          <= 1'b0;
      op_err       <= 1'b0;
      cur_valid    <= 1'b0;
      cur_idx      <= '0;
      reported     <= '0;
      name_hi      <= '0;
      copy_valid   <= 1'b0;
      copy_addr    <= '0;
      copy_index   <= '0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      copy_valid   <= 1'b0;

      if (reg_rd_en) begin
        if (ofs == OFS_OP) begin
          if (cur_valid) reported[cur_idx] <= 1'b1;
          if (found) begin
            cur_valid   <= 1'b1;
            cur_idx     <= hit_idx;
            reg_rd_data <= ANS_ADD;
          end else begin
            cur_valid   <= 1'b0;
            reg_rd_data <= ANS_DONE;
            irq         <= 1'b0;
          end
        end else begin
          reg_rd_data <= prop_val;
        end
      end

      if (wr_ok) begin
        case (ofs)
          OFS_OP: begin
            if (reg_wdata == CMD_RESTART) begin
              reported  <= '0;
              cur_valid <= 1'b0;
              if (count != '0) irq <= 1'b1;
            end else begin
              op_err <= 1'b1;
            end
          end
          OFS_NAME_HI: name_hi <= reg_wdata;
          OFS_NAME_CPY: begin
            if (cur_valid) begin
              copy_valid <= 1'b1;
              copy_addr  <= {name_hi, reg_wdata};
              copy_index <= cur_idx;
            end
          end
          default: ;
        endcase
      end

      if (ld_fire) irq <= 1'b1;
    end
  end

endmodule

// File: rtl/enum_bus_ctrl.sv
module enum_bus_ctrl
  import enum_bus_pkg::*;
#(
  parameter int          MAX_DEV       = 16,
  parameter int          ADDR_W        = 8,
  parameter logic [31:0] SELF_NAME_LEN = 32'd16,
  parameter int          IDXW          = $clog2(MAX_DEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rd_valid,
  output logic [31:0]       reg_rd_data,
  output logic              irq,
  output logic              op_err,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [31:0]       ld_name_len,
  input  logic [31:0]       ld_id,
  input  logic [31:0]       ld_io_base,
  input  logic [31:0]       ld_io_size,
  input  logic [31:0]       ld_irq_base,
  input  logic [31:0]       ld_irq_count,
  output logic              copy_valid,
  output logic [63:0]       copy_addr,
  output logic [IDXW-1:0]   copy_index
);

  localparam int CNTW = $clog2(MAX_DEV + 1);

  dev_rec_t            ld_rec;
  dev_rec_t            cur_rec;
  logic                ld_fire;
  logic [CNTW-1:0]     count;
  logic [IDXW-1:0]     cur_idx;
  logic [MAX_DEV-1:0]  reported;
  logic [CNTW-1:0]     start_idx;
  logic                found;
  logic [IDXW-1:0]     hit_idx;

  assign ld_rec = '{name_len: ld_name_len, id: ld_id, io_base: ld_io_base,
                    io_size: ld_io_size, irq_base: ld_irq_base, irq_cnt: ld_irq_count};

  enum_dev_table #(
    .MAX_DEV(MAX_DEV), .IDXW(IDXW), .CNTW(CNTW), .SELF_NAME_LEN(SELF_NAME_LEN)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_rec(ld_rec),
    .ld_ready(ld_ready), .ld_fire(ld_fire), .count(count),
    .rd_idx(cur_idx), .rd_rec(cur_rec)
  );

  enum_scan #(.MAX_DEV(MAX_DEV), .IDXW(IDXW), .CNTW(CNTW)) u_scan (
    .count(count), .reported(reported), .start_idx(start_idx),
    .found(found), .hit_idx(hit_idx)
  );

  enum_regif #(.MAX_DEV(MAX_DEV), .IDXW(IDXW), .CNTW(CNTW), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_valid(reg_rd_valid),
    .reg_rd_data(reg_rd_data), .irq(irq), .op_err(op_err), .ld_fire(ld_fire),
    .count(count), .cur_idx(cur_idx), .cur_rec(cur_rec), .reported(reported),
    .start_idx(start_idx), .found(found), .hit_idx(hit_idx),
    .copy_valid(copy_valid), .copy_addr(copy_addr), .copy_index(copy_index)
  );

endmodule

// File: rtl/enum_bus_chk.sv
module enum_bus_chk
  import enum_bus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd_en,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              reg_rd_valid,
  input logic [31:0]       reg_rd_data,
  input logic              irq,
  input logic              op_err,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              copy_valid,
  input logic [63:0]       copy_addr
);

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);

  // R3
  restart_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_rd_en && (8'(reg_addr) == OFS_OP) && (reg_wdata == CMD_RESTART)) |=> irq);

  // R4
  op_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_valid && $past(reg_rd_en) && ($past(8'(reg_addr)) == OFS_OP))
      |-> ((reg_rd_data == ANS_ADD) || (reg_rd_data == ANS_DONE)));

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (reg_rd_valid && (reg_rd_data == ANS_DONE)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |=> op_err);

  // R9
  copy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> ($past(reg_wr_en) && ($past(8'(reg_addr)) == OFS_NAME_CPY)
                    && (copy_addr[31:0] == $past(reg_wdata))));

  // R11
  load_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> irq);

endmodule

bind enum_bus_ctrl enum_bus_chk #(.ADDR_W(ADDR_W)) u_enum_bus_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_valid(reg_rd_valid),
  .reg_rd_data(reg_rd_data), .irq(irq), .op_err(op_err), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .copy_valid(copy_valid), .copy_addr(copy_addr)
);

// File: tb/test_enum_bus_ctrl.sv
module test_enum_bus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd_valid;
  logic [31:0] reg_rd_data;
  logic        irq, op_err;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [31:0] ld_name_len = '0, ld_id = '0, ld_io_base = '0;
  logic [31:0] ld_io_size = '0, ld_irq_base = '0, ld_irq_count = '0;
  logic        copy_valid;
  logic [63:0] copy_addr;
  logic [3:0]  copy_index;

  int checks = 0;
  int fails  = 0;
  logic        cap_cv;
  logic [63:0] cap_ca;
  logic [3:0]  cap_ci;
  logic [31:0] rv;

  always #5 clk = ~clk;

  enum_bus_ctrl i_enum_bus_ctrl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd_en = 1'b0;
    chk("R2 rd_valid", 64'(reg_rd_valid), 64'd1);
    d = reg_rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
    cap_cv = copy_valid; cap_ca = copy_addr; cap_ci = copy_index;
  endtask

  task automatic ld(input logic [31:0] id, input logic [31:0] base, input logic [31:0] sz,
                    input logic [31:0] ib, input logic [31:0] ic, input logic [31:0] nl);
    ld_valid = 1'b1; ld_id = id; ld_io_base = base; ld_io_size = sz;
    ld_irq_base = ib; ld_irq_count = ic; ld_name_len = nl;
    chk("R11 ld_ready before load", 64'(ld_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    chk("R11 irq after load", 64'(irq), 64'd1);
  endtask

  // {is_write, offset, wdata, expected read data}
  localparam int NV = 11;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h8},
    {1'b0, 8'h08, 32'h0, 32'd16},
    {1'b0, 8'h0C, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 8'h10, 32'h0, 32'h1000_1000},
    {1'b0, 8'h14, 32'h0, 32'h0000_1000},
    {1'b0, 8'h18, 32'h0, 32'd1},
    {1'b0, 8'h1C, 32'h0, 32'd1},
    {1'b0, 8'h00, 32'h0, 32'h0},
    {1'b0, 8'h0C, 32'h0, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0}
  };

  task automatic run_main;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 op_err", 64'(op_err), 64'd0);
    chk("R1 rd_valid", 64'(reg_rd_valid), 64'd0);
    chk("R1 copy_valid", 64'(copy_valid), 64'd0);
    chk("R1 ld_ready", 64'(ld_ready), 64'd1);
    rd(8'h0C, rv); chk("R1 no current entry", 64'(rv), 64'd0);

    // R4 self entry walk, R6 done, R7 zero properties
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], rv);
        chk($sformatf("R4/R6/R7 vector %0d", i), 64'(rv), 64'(VEC[i][31:0]));
      end
    end
    chk("R6 irq after done", 64'(irq), 64'd0);

    ld(32'h11, 32'h2000, 32'h100, 32'd5, 32'd2, 32'd7);
    ld(32'h22, 32'h3000, 32'h200, 32'd7, 32'd1, 32'd4);

    wr(8'h00, 32'h0);
    chk("R3 irq after restart", 64'(irq), 64'd1);
    rd(8'h00, rv); chk("R3 restart rescans self", 64'(rv), 64'd8);
    rd(8'h0C, rv); chk("R4 first is self", 64'(rv), 64'hFFFF_FFFF);
    chk("R6 irq kept on add answer", 64'(irq), 64'd1);
    rd(8'h00, rv); chk("R4 add A", 64'(rv), 64'd8);
    rd(8'h0C, rv); chk("R4 id A", 64'(rv), 64'h11);
    rd(8'h1C, rv); chk("R4 irq count A", 64'(rv), 64'd2);

    wr(8'h20, 32'hABCD_0001);
    wr(8'h04, 32'h1234_5678);
    chk("R9 copy pulse", 64'(cap_cv), 64'd1);
    chk("R9 copy addr", cap_ca, 64'hABCD_0001_1234_5678);
    chk("R9 copy index", 64'(cap_ci), 64'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", 64'(copy_valid), 64'd0);

    wr(8'h00, 32'h5);
    chk("R8 err set", 64'(op_err), 64'd1);
    chk("R8 irq unchanged", 64'(irq), 64'd1);
    rd(8'h0C, rv); chk("R8 current kept", 64'(rv), 64'h11);
    rd(8'h00, rv); chk("R8 scan continues", 64'(rv), 64'd8);
    rd(8'h0C, rv); chk("R8 next is B", 64'(rv), 64'h22);

    ld(32'h33, 32'h4000, 32'h80, 32'd9, 32'd1, 32'd3);
    rd(8'h00, rv); chk("R12 appended found", 64'(rv), 64'd8);
    rd(8'h0C, rv); chk("R12 id C", 64'(rv), 64'h33);
    rd(8'h00, rv); chk("R6 done", 64'(rv), 64'd0);
    chk("R6 irq low", 64'(irq), 64'd0);
    wr(8'h04, 32'hCAFE);
    chk("R10 no pulse", 64'(cap_cv), 64'd0);
    rd(8'h10, rv); chk("R7 base zero", 64'(rv), 64'd0);
    rd(8'h00, rv); chk("R5 done again", 64'(rv), 64'd0);
    chk("R8 err sticky", 64'(op_err), 64'd1);

    ld(32'h44, 32'h5000, 32'h40, 32'd11, 32'd1, 32'd5);
    rd(8'h00, rv); chk("R5 skip reported", 64'(rv), 64'd8);
    rd(8'h0C, rv); chk("R5 only D found", 64'(rv), 64'h44);
    rd(8'h00, rv); chk("R5 done after D", 64'(rv), 64'd0);

    wr(8'h00, 32'h0);
    rd(8'h00, rv); chk("R13 select self", 64'(rv), 64'd8);
    wr(8'h10, 32'hDEAD);
    rd(8'h10, rv); chk("R13 base unchanged", 64'(rv), 64'h1000_1000);
    rd(8'h04, rv); chk("R13 name reg reads 0", 64'(rv), 64'd0);
    rd(8'h20, rv); chk("R13 upper reg reads 0", 64'(rv), 64'd0);

    for (int i = 0; i < 11; i++) ld(32'h100 + i, 32'h8000, 32'h10, 32'd20, 32'd1, 32'd2);
    chk("R11 full table not ready", 64'(ld_ready), 64'd0);
  endtask

  initial begin
    fork
      run_main;
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule